// File: doc/BRIEF.md
# Transport Stream Output Pacer

The pacer turns a byte-wide queue of 188-byte transport stream packets into a paced, byte-parallel output stream. Every byte it emits is marked by a one-cycle valid strobe that acts as the output clock enable. The pacing comes from "byte slots": a slot is issued either by a 13-bit phase accumulator, which gives fine-grained rates, or by a small integer divider of one of two reference tick inputs. Each slot carries at most one output byte. After each packet the pacer can insert an idle gap of a programmable number of slots.

A packet from the input queue starts only when the queue reports a whole packet and its head byte is flagged as start-of-packet. If no such packet is waiting when a slot could start one, the pacer can fill the slot with a generated null packet. That null packet can optionally be marked with the transport error indicator. Two 32-bit control words configure the block. Except for the hold bit, a change to either word is taken up only between packets, so a packet that has started always finishes with the settings it started with. Two counters report completed packets and inserted null packets.

Top module: `tsout_pacer`

## Requirements
- R1: With ctrl_word bit 0 (run) clear at a packet boundary, no new packet starts and out_valid stays low.
- R2: While ctrl_word bit 1 (hold) is set, the block is held in reset: out_valid is low from the next cycle, and pkt_count, null_count and the pacing state return to zero.
- R3: With ctrl_word bit 5 (fill) set, a slot that finds no whole packet ready starts a null packet. Its bytes are 0x47 at index 0, 0x1F at index 1, 0xFF at index 2, 0x10 at index 3 and 0xFF at indices 4 to 187. out_sop is high on index 0 only.
- R4: With ctrl_word bit 7 (mark) set, byte index 1 of every inserted null packet is 0x9F: the error indicator at bit 7 is set.
- R5: A queue packet starts only when in_pkt_avail, in_valid and in_sop are all high. Its 188 bytes are output unchanged and in order, with one in_ready pulse per byte.
- R6: With fill clear and no whole packet ready, the output stays idle, even with part of a packet queued, until a whole packet is available.
- R7: With ctrl_word bit 4 (gap) set, exactly 2*g+4 slots pass without output between the last byte of a packet and the next packet. Here g is rate_word bits 6:0. With gap clear, the next packet can take the very next slot.
- R8: A started packet is never cut short by a change to run, fill, mark or rate. Such changes take effect at the next packet boundary.
- R9: With ctrl_word bit 12 (nco) clear, a slot is issued every v+1 ticks, where v is rate_word bits 19:16. The tick is base_tick when ctrl_word bit 11 is clear and fast_tick when it is set. Bits 31:20 are ignored.
- R10: With nco set, each base_tick adds rate_word bits 31:16 to a 13-bit accumulator, and a slot is issued on each carry out of it. A value of 8192 or more gives a slot on every tick.
- R11: pkt_count increments once at the end of every packet. null_count increments once at the end of every inserted null packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_word | input | 32 | Main control word (run, hold, gap, fill, mark, fast reference, nco) |
| rate_word | input | 32 | Gap size in bits 6:0, rate value in bits 31:16 |
| base_tick | input | 1 | Base reference tick enable |
| fast_tick | input | 1 | Fast reference tick enable (divider mode only) |
| in_data | input | 8 | Head byte of the input queue |
| in_valid | input | 1 | Input queue not empty |
| in_sop | input | 1 | Head byte is the first byte of a packet |
| in_pkt_avail | input | 1 | Queue holds at least one whole packet |
| in_ready | output | 1 | Head byte is taken at this clock edge |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output clock enable, one cycle per byte |
| out_sop | output | 1 | Output byte is the first of a packet |
| pkt_count | output | 16 | Completed packets, wrapping |
| null_count | output | 16 | Completed null packets, wrapping |

## Verification
The bound checker watches packet framing on every cycle. A start of packet may only follow zero or exactly 188 bytes, and no byte may appear outside a packet. It also checks that hold and an idle disabled state silence the output, that every null packet opens with the sync byte, and that null_count never moves without pkt_count. The directed scenarios cover what only a stimulus can show: the exact null and error-flag contents, byte-exact queue pass-through, the slot spacing of the divider, the reference select and the accumulator, the measured gap length, and settings changed mid-packet that only take effect at the boundary.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned GAP_W    = 7;
   localparam int unsigned RATE_W   = 16;
   localparam int unsigned RATE_LSB = 16;
   localparam int unsigned DIV_W    = 4;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_GAP  = 2'd2
   } tsp_state_e;

   // decoded configuration, sampled only between packets
   typedef struct packed {
      logic              run;
      logic              gap_on;
      logic              fill_on;
      logic              mark_err;
      logic              fast_ref;
      logic              nco_on;
      logic [GAP_W-1:0]  gap_size;
      logic [RATE_W-1:0] rate_val;
   } tsp_cfg_t;

endpackage

// File: rtl/tsp_rate_gen.sv
module tsp_rate_gen #(
   parameter int unsigned ACC_W   = 13,
   parameter int unsigned RATE_W  = 16,
   parameter int unsigned DIV_W   = 4,
   parameter bit          HAS_NCO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              nco_on,
   input  logic              fast_ref,
   input  logic [RATE_W-1:0] rate_val,
   input  logic              base_tick,
   input  logic              fast_tick,
   output logic              slot
);

   logic             div_tick;
   logic             div_hit;
   logic             nco_hit;
   logic [DIV_W-1:0] div_cnt;

   assign div_tick = fast_ref ? fast_tick : base_tick;
   assign div_hit  = div_tick && (div_cnt == rate_val[DIV_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
      end else if (clr) begin
         div_cnt <= '0;
      end else if (div_tick) begin
         div_cnt <= div_hit ? '0 : div_cnt + DIV_W'(1);
      end
   end

   generate
      if (HAS_NCO) begin : g_nco
         localparam int unsigned SUM_W = ((RATE_W > ACC_W) ? RATE_W : ACC_W) + 1;
         logic [ACC_W-1:0] acc;
         logic [SUM_W-1:0] sum;

         assign sum     = SUM_W'(acc) + SUM_W'(rate_val);
         assign nco_hit = base_tick && (sum[SUM_W-1:ACC_W] != '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc <= '0;
            end else if (clr) begin
               acc <= '0;
            end else if (base_tick && nco_on) begin
               acc <= sum[ACC_W-1:0];
            end
         end
      end else begin : g_div_only
         assign nco_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot <= 1'b0;
      end else if (clr) begin
         slot <= 1'b0;
      end else begin
         slot <= (HAS_NCO && nco_on) ? nco_hit : div_hit;
      end
   end

endmodule

// File: rtl/tsp_null_byte.sv
module tsp_null_byte #(
   parameter int unsigned IDX_W    = 8,
   parameter logic [12:0] NULL_PID = 13'h1FFF,
   parameter logic [7:0]  SYNC     = 8'h47,
   parameter logic [7:0]  FILL     = 8'hFF
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             mark_err,
   output logic [7:0]       data
);

   always_comb begin
      if (idx == IDX_W'(0)) begin
         data = SYNC;
      end else if (idx == IDX_W'(1)) begin
         data = {mark_err, 2'b00, NULL_PID[12:8]};
      end else if (idx == IDX_W'(2)) begin
         data = NULL_PID[7:0];
      end else if (idx == IDX_W'(3)) begin
         data = 8'h10;
      end else begin
         data = FILL;
      end
   end

endmodule

// File: rtl/tsp_seq.sv
module tsp_seq
   import tsp_pkg::*;
#(
   parameter int unsigned PKT_LEN = 188,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned CNT_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              slot,
   input  tsp_cfg_t          live_cfg,
   output tsp_cfg_t          eff_cfg,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic              in_pkt_avail,
   output logic              in_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              out_sop,
   output logic [CNT_W-1:0]  pkt_count,
   output logic [CNT_W-1:0]  null_count,
   output logic              idle,
   output logic              sending_null
);

   localparam int unsigned    IDX_W    = $clog2(PKT_LEN);
   localparam int unsigned    GCNT_W   = GAP_W + 2;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

   tsp_state_e        st;
   tsp_cfg_t          act_cfg;
   logic [IDX_W-1:0]  idx;
   logic [GCNT_W-1:0] gap_left;
   logic [GCNT_W-1:0] gap_load;
   logic              from_null;
   logic              head_ok;
   logic              start_fifo;
   logic              start_null;
   logic              send_slot;
   logic              last_slot;
   logic [IDX_W-1:0]  null_idx;
   logic [7:0]        null_data;

   // between packets the live words steer; inside a packet the latched copy does
   assign eff_cfg    = (st == ST_IDLE) ? live_cfg : act_cfg;
   assign head_ok    = in_pkt_avail && in_valid && in_sop;
   assign start_fifo = (st == ST_IDLE) && slot && eff_cfg.run && head_ok;
   assign start_null = (st == ST_IDLE) && slot && eff_cfg.run && !head_ok && eff_cfg.fill_on;
   assign send_slot  = (st == ST_SEND) && slot;
   assign last_slot  = send_slot && (idx == LAST_IDX);
   assign in_ready   = start_fifo || (send_slot && !from_null);
   assign null_idx   = (st == ST_IDLE) ? '0 : idx;
   assign gap_load   = GCNT_W'({eff_cfg.gap_size, 1'b0}) + GCNT_W'(4);
   assign idle       = (st == ST_IDLE);
   assign sending_null = from_null;

   tsp_null_byte #(
      .IDX_W (IDX_W)
   ) u_null (
      .idx      (null_idx),
      .mark_err (eff_cfg.mark_err),
      .data     (null_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         act_cfg    <= '0;
         idx        <= '0;
         gap_left   <= '0;
         from_null  <= 1'b0;
         out_data   <= '0;
         out_valid  <= 1'b0;
         out_sop    <= 1'b0;
         pkt_count  <= '0;
         null_count <= '0;
      end else if (clr) begin
         st         <= ST_IDLE;
         act_cfg    <= '0;
         idx        <= '0;
         gap_left   <= '0;
         from_null  <= 1'b0;
         out_data   <= '0;
         out_valid  <= 1'b0;
         out_sop    <= 1'b0;
         pkt_count  <= '0;
         null_count <= '0;
      end else begin
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               act_cfg <= live_cfg;
               if (start_fifo || start_null) begin
                  st        <= ST_SEND;
                  idx       <= IDX_W'(1);
                  from_null <= start_null;
                  out_valid <= 1'b1;
                  out_sop   <= 1'b1;
                  out_data  <= start_fifo ? in_data : DATA_W'(null_data);
               end
            end
            ST_SEND: begin
               if (send_slot) begin
                  out_valid <= 1'b1;
                  out_data  <= from_null ? DATA_W'(null_data) : in_data;
                  idx       <= idx + IDX_W'(1);
                  if (last_slot) begin
                     pkt_count <= pkt_count + CNT_W'(1);
                     if (from_null) begin
                        null_count <= null_count + CNT_W'(1);
                     end
                     if (act_cfg.gap_on) begin
                        st       <= ST_GAP;
                        gap_left <= gap_load;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
            end
            ST_GAP: begin
               if (slot) begin
                  gap_left <= gap_left - GCNT_W'(1);
                  if (gap_left == GCNT_W'(1)) begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tsout_pacer.sv
module tsout_pacer
   import tsp_pkg::*;
#(
   parameter int unsigned PKT_LEN = 188,
   parameter int unsigned ACC_W   = 13,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned DATA_W  = 8,
   parameter bit          HAS_NCO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       ctrl_word,
   input  logic [31:0]       rate_word,
   input  logic              base_tick,
   input  logic              fast_tick,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic              in_pkt_avail,
   output logic              in_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              out_sop,
   output logic [CNT_W-1:0]  pkt_count,
   output logic [CNT_W-1:0]  null_count
);

   if (DATA_W != 8) begin : g_bad_width
      $error("tsout_pacer: DATA_W must be 8");
   end
   if (PKT_LEN < 8 || PKT_LEN > 4096) begin : g_bad_len
      $error("tsout_pacer: PKT_LEN out of range");
   end
   if (ACC_W < 2 || ACC_W >= RATE_W + 1) begin : g_bad_acc
      $error("tsout_pacer: ACC_W out of range");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("tsout_pacer: CNT_W must be positive");
   end

   tsp_cfg_t live_cfg;
   tsp_cfg_t eff_cfg;
   logic     hold;
   logic     slot;
   logic     seq_idle;
   logic     seq_null;
   logic     unused_cfg_bits;

   assign hold              = ctrl_word[1];
   assign live_cfg.run      = ctrl_word[0];
   assign live_cfg.gap_on   = ctrl_word[4];
   assign live_cfg.fill_on  = ctrl_word[5];
   assign live_cfg.mark_err = ctrl_word[7];
   assign live_cfg.fast_ref = ctrl_word[11];
   assign live_cfg.nco_on   = ctrl_word[12];
   assign live_cfg.gap_size = rate_word[GAP_W-1:0];
   assign live_cfg.rate_val = rate_word[RATE_LSB +: RATE_W];

   assign unused_cfg_bits = ^{ctrl_word[31:13], ctrl_word[10:8], ctrl_word[6],
                              ctrl_word[3:2], rate_word[15:GAP_W]};

   tsp_rate_gen #(
      .ACC_W   (ACC_W),
      .RATE_W  (RATE_W),
      .DIV_W   (DIV_W),
      .HAS_NCO (HAS_NCO)
   ) u_rate (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (hold),
      .nco_on    (eff_cfg.nco_on),
      .fast_ref  (eff_cfg.fast_ref),
      .rate_val  (eff_cfg.rate_val),
      .base_tick (base_tick),
      .fast_tick (fast_tick),
      .slot      (slot)
   );

   tsp_seq #(
      .PKT_LEN (PKT_LEN),
      .DATA_W  (DATA_W),
      .CNT_W   (CNT_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr          (hold),
      .slot         (slot),
      .live_cfg     (live_cfg),
      .eff_cfg      (eff_cfg),
      .in_data      (in_data),
      .in_valid     (in_valid),
      .in_sop       (in_sop),
      .in_pkt_avail (in_pkt_avail),
      .in_ready     (in_ready),
      .out_data     (out_data),
      .out_valid    (out_valid),
      .out_sop      (out_sop),
      .pkt_count    (pkt_count),
      .null_count   (null_count),
      .idle         (seq_idle),
      .sending_null (seq_null)
   );

endmodule

// File: rtl/tsout_pacer_chk.sv
module tsout_pacer_chk #(
   parameter int unsigned PKT_LEN = 188,
   parameter int unsigned CNT_W   = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hold,
   input logic             live_run,
   input logic             idle,
   input logic             sending_null,
   input logic             out_valid,
   input logic             out_sop,
   input logic [7:0]       out_data,
   input logic [CNT_W-1:0] pkt_count,
   input logic [CNT_W-1:0] null_count
);

   localparam int unsigned BC_W = $clog2(PKT_LEN + 1);

   logic [BC_W-1:0] byte_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_cnt <= '0;
      end else if (hold) begin
         byte_cnt <= '0;
      end else if (out_valid) begin
         byte_cnt <= out_sop ? BC_W'(1) : byte_cnt + BC_W'(1);
      end
   end

   assert_hold_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !out_valid);

   assert_idle_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !live_run) |=> !out_valid);

   assert_sop_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sop) |-> (byte_cnt == '0 || byte_cnt == BC_W'(PKT_LEN)));

   assert_no_stray_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_sop) |-> (byte_cnt != '0 && byte_cnt < BC_W'(PKT_LEN)));

   assert_null_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sop && sending_null) |-> (out_data == 8'h47));

   assert_null_counted_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (null_count != $past(null_count)) |-> (pkt_count != $past(pkt_count)));

endmodule

bind tsout_pacer tsout_pacer_chk #(
   .PKT_LEN (PKT_LEN),
   .CNT_W   (CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hold         (ctrl_word[1]),
   .live_run     (ctrl_word[0]),
   .idle         (seq_idle),
   .sending_null (seq_null),
   .out_valid    (out_valid),
   .out_sop      (out_sop),
   .out_data     (out_data),
   .pkt_count    (pkt_count),
   .null_count   (null_count)
);

// File: tb/tsout_pacer_test.sv
`timescale 1ns/1ps
module tsout_pacer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ctrl_word = '0;
   logic [31:0] rate_word = '0;
   logic        base_tick = 1'b1;
   logic        fast_tick = 1'b1;
   logic [7:0]  in_data;
   logic        in_valid;
   logic        in_sop;
   logic        in_pkt_avail;
   logic        in_ready;
   logic [7:0]  out_data;
   logic        out_valid;
   logic        out_sop;
   logic [15:0] pkt_count;
   logic [15:0] null_count;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit base_half = 1'b0;

   // input queue model
   logic [7:0] fmem [0:4095];
   bit         fsop [0:4095];
   int         wr_ptr = 0;
   int         rd_ptr = 0;

   // capture of output bytes
   logic [7:0] cap_d [$];
   bit         cap_s [$];
   int         cap_c [$];

   always #4 clk = ~clk;

   assign in_data      = fmem[rd_ptr % 4096];
   assign in_valid     = (wr_ptr != rd_ptr);
   assign in_sop       = in_valid && fsop[rd_ptr % 4096];
   assign in_pkt_avail = (wr_ptr - rd_ptr) >= 188;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (in_ready && in_valid) rd_ptr <= rd_ptr + 1;
      base_tick <= base_half ? ~base_tick : 1'b1;
   end

   always @(negedge clk) begin
      if (out_valid) begin
         cap_d.push_back(out_data);
         cap_s.push_back(out_sop);
         cap_c.push_back(cyc);
      end
   end

   tsout_pacer uut (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .rate_word(rate_word),
      .base_tick(base_tick), .fast_tick(fast_tick),
      .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop),
      .in_pkt_avail(in_pkt_avail), .in_ready(in_ready),
      .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop),
      .pkt_count(pkt_count), .null_count(null_count)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step;
      @(negedge clk);
      #1;
   endtask

   task automatic clear_cap;
      cap_d.delete();
      cap_s.delete();
      cap_c.delete();
   endtask

   task automatic wait_bytes(input int n);
      int t = 0;
      while (cap_d.size() < n && t < 8000) begin
         step();
         t++;
      end
   endtask

   task automatic stop_and_drain;
      ctrl_word = 32'h0;
      repeat (1600) step();
   endtask

   task automatic push_packet(input int n, input int key, input bit first);
      for (int i = 0; i < n; i++) begin
         fmem[wr_ptr % 4096] = (first && i == 0) ? 8'h47 : 8'((i * 7 + key) & 8'hFF);
         fsop[wr_ptr % 4096] = first && (i == 0);
         wr_ptr++;
      end
   endtask

   task automatic t_reset;
      check(out_valid == 1'b0, "R2 reset out_valid", int'(out_valid), 0);
      check(pkt_count == 16'd0 && null_count == 16'd0, "R2 reset counters", int'(pkt_count), 0);
      check(in_ready == 1'b0, "R5 reset in_ready", int'(in_ready), 0);
   endtask

   task automatic t_disabled;
      clear_cap();
      ctrl_word = 32'h0000_0020;   // fill on, run off
      rate_word = 32'h0;
      repeat (600) step();
      check(cap_d.size() == 0, "R1 no bytes while run clear", cap_d.size(), 0);
      check(pkt_count == 16'd0, "R1 no packets while run clear", int'(pkt_count), 0);
      ctrl_word = 32'h0;
   endtask

   task automatic t_null(input bit mark, input string tag);
      int p0 = int'(pkt_count);
      int n0 = int'(null_count);
      int bad = 0;
      clear_cap();
      rate_word = 32'h0;
      ctrl_word = mark ? 32'h0000_00A1 : 32'h0000_0021;
      wait_bytes(100);
      ctrl_word = 32'h0;           // mid-packet stop, applies at boundary (R8)
      repeat (1000) step();
      check(cap_d.size() == 188, {tag, " R8 packet completes after stop"}, cap_d.size(), 188);
      if (cap_d.size() >= 188) begin
         for (int i = 0; i < 188; i++) begin
            logic [7:0] e;
            e = (i == 0) ? 8'h47 : (i == 1) ? (mark ? 8'h9F : 8'h1F) : (i == 3) ? 8'h10 : 8'hFF;
            if (cap_d[i] !== e || cap_s[i] != (i == 0)) bad++;
         end
         check(cap_d[1] == (mark ? 8'h9F : 8'h1F), {tag, " R4 error flag byte"}, int'(cap_d[1]),
               mark ? 32'h9F : 32'h1F);
      end
      check(bad == 0, {tag, " R3 null packet bytes"}, bad, 0);
      check(int'(pkt_count) == p0 + 1, {tag, " R11 pkt_count"}, int'(pkt_count), p0 + 1);
      check(int'(null_count) == n0 + 1, {tag, " R11 null_count"}, int'(null_count), n0 + 1);
   endtask

   task automatic t_fifo;
      int p0 = int'(pkt_count);
      int n0 = int'(null_count);
      int bad = 0;
      clear_cap();
      rate_word = 32'h0;
      ctrl_word = 32'h0000_0001;   // run, no fill
      repeat (300) step();
      check(cap_d.size() == 0, "R6 idle with empty queue", cap_d.size(), 0);
      push_packet(100, 1, 1'b1);
      repeat (300) step();
      check(cap_d.size() == 0, "R6 idle with partial packet", cap_d.size(), 0);
      push_packet(88, 101, 1'b0);
      push_packet(188, 2, 1'b1);
      wait_bytes(376);
      repeat (50) step();
      check(cap_d.size() == 376, "R5 two queue packets output", cap_d.size(), 376);
      if (cap_d.size() >= 376) begin
         for (int i = 0; i < 376; i++) begin
            logic [7:0] e;
            int j = i % 188;
            if (j == 0) e = 8'h47;
            else if (i < 100) e = 8'((j * 7 + 1) & 8'hFF);
            else if (i < 188) e = 8'(((j - 100) * 7 + 101) & 8'hFF);
            else e = 8'((j * 7 + 2) & 8'hFF);
            if (cap_d[i] !== e || cap_s[i] != (j == 0)) bad++;
         end
      end
      check(bad == 0, "R5 queue bytes unchanged", bad, 0);
      check(rd_ptr == wr_ptr, "R5 one in_ready per byte", rd_ptr, wr_ptr);
      check(int'(pkt_count) == p0 + 2, "R11 pkt_count for queue packets", int'(pkt_count), p0 + 2);
      check(int'(null_count) == n0, "R11 null_count unchanged", int'(null_count), n0);
      stop_and_drain();
   endtask

   task automatic t_gap(input logic [31:0] ctrl, input logic [31:0] rate, input int exp, input string tag);
      clear_cap();
      rate_word = rate;
      ctrl_word = ctrl;
      wait_bytes(189);
      ctrl_word = 32'h0;
      repeat (1000) step();
      check(cap_d.size() == 376, {tag, " two packets"}, cap_d.size(), 376);
      if (cap_d.size() >= 189)
         check(cap_c[188] - cap_c[187] == exp && cap_s[188], {tag, " gap spacing"},
               cap_c[188] - cap_c[187], exp);
   endtask

   task automatic t_rate(input logic [31:0] ctrl, input logic [31:0] rate, input bit half,
                         input int exp, input string tag);
      clear_cap();
      base_half = half;
      rate_word = rate;
      ctrl_word = ctrl;
      wait_bytes(10);
      if (cap_d.size() >= 10) begin
         check(cap_c[7] - cap_c[6] == exp, {tag, " slot spacing"}, cap_c[7] - cap_c[6], exp);
         check(cap_c[9] - cap_c[8] == exp, {tag, " slot spacing again"}, cap_c[9] - cap_c[8], exp);
      end else begin
         check(1'b0, {tag, " bytes produced"}, cap_d.size(), 10);
      end
      stop_and_drain();
      base_half = 1'b0;
   endtask

   task automatic t_hold;
      clear_cap();
      rate_word = 32'h0;
      ctrl_word = 32'h0000_0021;
      wait_bytes(50);
      ctrl_word = 32'h0000_0022;   // hold
      @(posedge clk);
      #1;
      clear_cap();
      repeat (20) step();
      check(cap_d.size() == 0, "R2 output quiet under hold", cap_d.size(), 0);
      check(pkt_count == 16'd0, "R2 pkt_count cleared", int'(pkt_count), 0);
      check(null_count == 16'd0, "R2 null_count cleared", int'(null_count), 0);
      ctrl_word = 32'h0000_0021;
      wait_bytes(1);
      check(cap_d.size() > 0 && cap_d[0] == 8'h47 && cap_s[0], "R2 fresh packet after hold",
            cap_d.size() > 0 ? int'(cap_d[0]) : -1, 32'h47);
      stop_and_drain();
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
   end

   initial begin
      repeat (4) step();
      t_reset();
      rst_n = 1'b1;
      repeat (4) step();
      t_reset();
      t_disabled();
      t_null(1'b0, "R3 plain");
      t_null(1'b1, "R4 marked");
      t_fifo();
      t_gap(32'h0000_0031, 32'h0000_0003, 11, "R7 gap g=3");
      t_gap(32'h0000_0021, 32'h0000_0003, 1, "R7 gap off");
      t_gap(32'h0000_0031, 32'h0000_0000, 5, "R7 gap g=0");
      t_rate(32'h0000_0021, 32'hABC3_0000, 1'b0, 4, "R9 divider v=3");
      t_rate(32'h0000_0021, 32'h0001_0000, 1'b1, 4, "R9 base reference");
      t_rate(32'h0000_0821, 32'h0001_0000, 1'b1, 2, "R9 fast reference");
      t_rate(32'h0000_1021, 32'h0800_0000, 1'b0, 4, "R10 nco 2048");
      t_rate(32'h0000_1021, 32'h1000_0000, 1'b0, 2, "R10 nco 4096");
      t_rate(32'h0000_1021, 32'h2000_0000, 1'b0, 1, "R10 nco 8192");
      t_hold();
      summary();
      $finish;
   end

endmodule